// File: doc/BRIEF.md
# Erase Range Region Walker

This block turns one erase request, given as a byte start address and a byte length, into a series of single-block erase commands for a flash device. The device is laid out as two regions. A small-block region sits at the bottom of the address space. A large-block region follows it and runs to the top of the device. The block first checks the request against this map. It then walks the range in ascending order and emits one block address per step to a downstream erase sequencer. It waits for the sequencer's verdict on each block before it issues the next one.

Requests arrive on a valid/ready channel. `req_ready` is high only while the walker is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. Block commands leave on a second valid/ready channel. When `ers_ready` is low, `ers_valid` stays high and `ers_addr` stays unchanged until the sequencer accepts the command. The sequencer answers each accepted command with a one-cycle `ers_rsp_valid` pulse and a failure flag. The walker samples that answer only while it is waiting for one. The outcome comes back as a one-cycle `done` pulse with a 2-bit code on `err`.

With the default parameters the device has 8 small blocks of 16 KiB, followed by 31 large blocks of 128 KiB. The small region ends at byte 0x20000 and the device ends at byte 0x400000.

Top module: `erase_range_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready`=1, `busy`=0, `done`=0, `ers_valid`=0.
- R2: A request whose start plus length (computed without wrap-around) is greater than the device size ends with `err`=1 (invalid range) and issues no block erase.
- R3: A non-zero-length request whose start address is not a multiple of the block size of the region holding that start ends with `err`=1 and issues no block erase. An address below 0x20000 is in the small region (16 KiB blocks). Any other address is in the large region (128 KiB blocks).
- R4: A non-zero-length request whose end address (start plus length) is not a multiple of the block size of the region holding the end ends with `err`=1 and issues no block erase. An end of exactly 0x20000 counts as the large region.
- R5: A zero-length request that stays inside the device ends with `err`=0 and issues no block erase, whatever its alignment.
- R6: A valid request issues exactly one command per block, in ascending order, starting at the start address. Each command address is the previous one plus 16 KiB while in the small region, and plus 128 KiB once the walk has reached the large region.
- R7: A failed block erase ends the walk at once with `err`=2. No further command is issued.
- R8: `done` is high for exactly one cycle per accepted request. When every block erases cleanly, `err`=0 during that cycle.
- R9: A request is accepted only while idle. `busy` goes high on the cycle after acceptance and stays high through the `done` cycle. `req_ready` is low throughout that time.
- R10: While `ers_valid` is high and `ers_ready` is low, `ers_valid` stays high and `ers_addr` holds its value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_start | input | ADDR_W | Request start byte address |
| req_len | input | ADDR_W | Request length in bytes |
| ers_valid | output | 1 | Block erase command present |
| ers_ready | input | 1 | Sequencer takes the command |
| ers_addr | output | ADDR_W | Byte address of the block to erase |
| ers_rsp_valid | input | 1 | Sequencer verdict for the outstanding block |
| ers_rsp_fail | input | 1 | Verdict is failure (qualified by ers_rsp_valid) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Outcome code: 0 ok, 1 invalid range, 2 erase failure |

## Verification
A cursor that switches step size at the wrong point shows up on `ers_addr`. The first large-region command lands 16 KiB or 128 KiB off, which makes it misaligned or leaves a gap. This appears on the first command after the crossing. A wrong remaining-length count shows up as one block too many or too few before `done`, and is seen at the end of the request. A wrong alignment or range decision shows up within two cycles of acceptance, as an early `done` with the wrong `err`, or as commands where none were due.

// File: rtl/erw_pkg.sv
package erw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } erw_state_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_RANGE = 2'd1,
    ERR_IO    = 2'd2
  } erw_err_e;

  localparam int NUM_PROBES = 2;
endpackage

// File: rtl/erw_region_map.sv
module erw_region_map #(
  parameter int ADDR_W      = 32,
  parameter int SMALL_BYTES = 16384,
  parameter int SMALL_COUNT = 8,
  parameter int LARGE_BYTES = 131072
) (
  input  logic [ADDR_W:0] addr,
  output logic            in_large,
  output logic            aligned
);
  localparam logic [ADDR_W:0] SMALL_END  = (ADDR_W+1)'(SMALL_BYTES * SMALL_COUNT);
  localparam logic [ADDR_W:0] SMALL_MASK = (ADDR_W+1)'(SMALL_BYTES - 1);
  localparam logic [ADDR_W:0] LARGE_MASK = (ADDR_W+1)'(LARGE_BYTES - 1);

  logic [ADDR_W:0] mask;

  always_comb begin
    in_large = (addr >= SMALL_END);
    mask     = in_large ? LARGE_MASK : SMALL_MASK;
    aligned  = ((addr & mask) == '0);
  end
endmodule

// File: rtl/erw_range_check.sv
module erw_range_check
  import erw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SMALL_BYTES = 16384,
  parameter int SMALL_COUNT = 8,
  parameter int LARGE_BYTES = 131072,
  parameter int LARGE_COUNT = 31
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] len,
  output logic              invalid,
  output logic              zero_len,
  output logic              start_large
);
  localparam logic [ADDR_W:0] DEV_SIZE =
    (ADDR_W+1)'(SMALL_BYTES * SMALL_COUNT + LARGE_BYTES * LARGE_COUNT);

  logic [NUM_PROBES-1:0][ADDR_W:0] probe;
  logic [NUM_PROBES-1:0]           probe_large;
  logic [NUM_PROBES-1:0]           probe_aligned;

  assign probe[0] = {1'b0, start_addr};
  assign probe[1] = {1'b0, start_addr} + {1'b0, len};

  for (genvar g = 0; g < NUM_PROBES; g++) begin : g_probe
    erw_region_map #(
      .ADDR_W      (ADDR_W),
      .SMALL_BYTES (SMALL_BYTES),
      .SMALL_COUNT (SMALL_COUNT),
      .LARGE_BYTES (LARGE_BYTES)
    ) u_map (
      .addr     (probe[g]),
      .in_large (probe_large[g]),
      .aligned  (probe_aligned[g])
    );
  end

  always_comb begin
    zero_len    = (len == '0);
    start_large = probe_large[0];
    invalid     = (probe[1] > DEV_SIZE) ||
                  (!zero_len && !(&probe_aligned));
  end
endmodule

// File: rtl/erw_cursor.sv
module erw_cursor #(
  parameter int ADDR_W      = 32,
  parameter int SMALL_BYTES = 16384,
  parameter int SMALL_COUNT = 8,
  parameter int LARGE_BYTES = 131072
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [ADDR_W-1:0] load_len,
  input  logic              set_region,
  input  logic              region_large,
  input  logic              step,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] rem_q,
  output logic              last_blk
);
  localparam logic [ADDR_W-1:0] SMALL_B   = ADDR_W'(SMALL_BYTES);
  localparam logic [ADDR_W-1:0] LARGE_B   = ADDR_W'(LARGE_BYTES);
  localparam logic [ADDR_W-1:0] SMALL_END = ADDR_W'(SMALL_BYTES * SMALL_COUNT);

  logic              large_q;
  logic [ADDR_W-1:0] step_bytes;
  logic [ADDR_W-1:0] addr_next;

  always_comb begin
    step_bytes = large_q ? LARGE_B : SMALL_B;
    addr_next  = addr_q + step_bytes;
    last_blk   = (rem_q == step_bytes);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rem_q   <= '0;
      large_q <= 1'b0;
    end else if (load) begin
      addr_q  <= load_addr;
      rem_q   <= load_len;
      large_q <= 1'b0;
    end else if (set_region) begin
      large_q <= region_large;
    end else if (step) begin
      addr_q <= addr_next;
      rem_q  <= rem_q - step_bytes;
      if (!large_q && addr_next == SMALL_END) large_q <= 1'b1;
    end
  end
endmodule

// File: rtl/erase_range_walker.sv
module erase_range_walker
  import erw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SMALL_BYTES = 16384,
  parameter int SMALL_COUNT = 8,
  parameter int LARGE_BYTES = 131072,
  parameter int LARGE_COUNT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_len,
  output logic              ers_valid,
  input  logic              ers_ready,
  output logic [ADDR_W-1:0] ers_addr,
  input  logic              ers_rsp_valid,
  input  logic              ers_rsp_fail,
  output logic              busy,
  output logic              done,
  output logic [1:0]        err
);
  erw_state_e        st_q, st_d;
  erw_err_e          err_q, err_d;
  logic              accept;
  logic              chk_invalid, chk_zero, chk_large;
  logic              cur_step, cur_last;
  logic [ADDR_W-1:0] cur_addr, cur_rem;

  assign accept = req_valid && (st_q == ST_IDLE);

  erw_cursor #(
    .ADDR_W      (ADDR_W),
    .SMALL_BYTES (SMALL_BYTES),
    .SMALL_COUNT (SMALL_COUNT),
    .LARGE_BYTES (LARGE_BYTES)
  ) u_cursor (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (accept),
    .load_addr    (req_start),
    .load_len     (req_len),
    .set_region   (st_q == ST_CHECK),
    .region_large (chk_large),
    .step         (cur_step),
    .addr_q       (cur_addr),
    .rem_q        (cur_rem),
    .last_blk     (cur_last)
  );

  erw_range_check #(
    .ADDR_W      (ADDR_W),
    .SMALL_BYTES (SMALL_BYTES),
    .SMALL_COUNT (SMALL_COUNT),
    .LARGE_BYTES (LARGE_BYTES),
    .LARGE_COUNT (LARGE_COUNT)
  ) u_check (
    .start_addr  (cur_addr),
    .len         (cur_rem),
    .invalid     (chk_invalid),
    .zero_len    (chk_zero),
    .start_large (chk_large)
  );

  always_comb begin
    st_d     = st_q;
    err_d    = err_q;
    cur_step = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_CHECK;
      ST_CHECK: begin
        if (chk_invalid) begin
          err_d = ERR_RANGE;
          st_d  = ST_DONE;
        end else if (chk_zero) begin
          err_d = ERR_NONE;
          st_d  = ST_DONE;
        end else begin
          st_d = ST_ISSUE;
        end
      end
      ST_ISSUE: if (ers_ready) st_d = ST_WAIT;
      ST_WAIT: begin
        if (ers_rsp_valid) begin
          if (ers_rsp_fail) begin
            err_d = ERR_IO;
            st_d  = ST_DONE;
          end else begin
            cur_step = 1'b1;
            if (cur_last) begin
              err_d = ERR_NONE;
              st_d  = ST_DONE;
            end else begin
              st_d = ST_ISSUE;
            end
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= ERR_NONE;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign err       = err_q;
  assign ers_valid = (st_q == ST_ISSUE);
  assign ers_addr  = cur_addr;
endmodule

// File: rtl/erw_walker_chk.sv
module erw_walker_chk #(
  parameter int ADDR_W      = 32,
  parameter int SMALL_BYTES = 16384,
  parameter int SMALL_COUNT = 8,
  parameter int LARGE_BYTES = 131072,
  parameter int LARGE_COUNT = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              ers_valid,
  input logic              ers_ready,
  input logic [ADDR_W-1:0] ers_addr,
  input logic              busy,
  input logic              done,
  input logic [1:0]        err
);
  localparam logic [ADDR_W-1:0] SMALL_END  = ADDR_W'(SMALL_BYTES * SMALL_COUNT);
  localparam logic [ADDR_W-1:0] DEV_SIZE   =
    ADDR_W'(SMALL_BYTES * SMALL_COUNT + LARGE_BYTES * LARGE_COUNT);
  localparam logic [ADDR_W-1:0] SMALL_MASK = ADDR_W'(SMALL_BYTES - 1);
  localparam logic [ADDR_W-1:0] LARGE_MASK = ADDR_W'(LARGE_BYTES - 1);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ers_valid && !done);

  p_blk_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ers_valid |-> (ers_addr < DEV_SIZE) &&
      (((ers_addr < SMALL_END) ? (ers_addr & SMALL_MASK) : (ers_addr & LARGE_MASK)) == '0));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err != 2'd3) && !ers_valid);

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready);

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ers_valid && !ers_ready |=> ers_valid && $stable(ers_addr));
endmodule

bind erase_range_walker erw_walker_chk #(
  .ADDR_W      (ADDR_W),
  .SMALL_BYTES (SMALL_BYTES),
  .SMALL_COUNT (SMALL_COUNT),
  .LARGE_BYTES (LARGE_BYTES),
  .LARGE_COUNT (LARGE_COUNT)
) u_walker_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ers_valid (ers_valid),
  .ers_ready (ers_ready),
  .ers_addr  (ers_addr),
  .busy      (busy),
  .done      (done),
  .err       (err)
);

// File: tb/erase_range_walker_bench.sv
module erase_range_walker_bench;
  localparam int     AW     = 32;
  localparam longint SB     = 16384;
  localparam longint LB     = 131072;
  localparam longint S_END  = SB * 8;
  localparam longint DEV    = S_END + LB * 31;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_start = '0;
  logic [AW-1:0] req_len = '0;
  logic          ers_valid;
  logic          ers_ready = 1'b0;
  logic [AW-1:0] ers_addr;
  logic          ers_rsp_valid = 1'b0;
  logic          ers_rsp_fail = 1'b0;
  logic          busy, done;
  logic [1:0]    err;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic [AW-1:0] got_addr [64];
  int            got_n = 0;
  int            fail_at = -1;
  logic          saw_done = 1'b0;
  logic [1:0]    done_err = 2'd0;
  logic          prev_v = 1'b0, prev_r = 1'b0, prev_done = 1'b0;
  logic [AW-1:0] prev_a = '0;
  logic          seq_wait = 1'b0;
  int            dly = 0;

  longint        exp_addr [64];
  int            exp_n;

  always #5 clk = ~clk;

  erase_range_walker u_erase_range_walker (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_start (req_start), .req_len (req_len),
    .ers_valid (ers_valid), .ers_ready (ers_ready), .ers_addr (ers_addr),
    .ers_rsp_valid (ers_rsp_valid), .ers_rsp_fail (ers_rsp_fail),
    .busy (busy), .done (done), .err (err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic longint blk_of(input longint a);
    return (a < S_END) ? SB : LB;
  endfunction

  function automatic int exp_code(input longint s, input longint l);
    longint e = s + l;
    if (e > DEV) return 1;
    if (l == 0) return 0;
    if (s % blk_of(s) != 0) return 1;
    if (e % blk_of(e) != 0) return 1;
    return 0;
  endfunction

  task automatic build_list(input longint s, input longint l);
    longint a = s;
    exp_n = 0;
    while (a < s + l && exp_n < 64) begin
      exp_addr[exp_n] = a;
      exp_n++;
      a += blk_of(a);
    end
  endtask

  // sequencer model and port monitor
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_done) check(!done, "R8 done width", longint'(done), 0);
      prev_done = done;
      if (prev_v && !prev_r)
        check(ers_valid && ers_addr == prev_a, "R10 hold", longint'(ers_addr), longint'(prev_a));
      if (prev_v && prev_r) begin
        if (got_n < 64) got_addr[got_n] = prev_a;
        got_n++;
        seq_wait = 1'b1;
        dly = int'($urandom % 3);
      end
      ers_rsp_valid = 1'b0;
      if (seq_wait) begin
        if (dly == 0) begin
          ers_rsp_valid = 1'b1;
          ers_rsp_fail  = ((got_n - 1) == fail_at);
          seq_wait = 1'b0;
        end else dly--;
      end
      if (!seq_wait && !ers_rsp_valid) ers_ready = (($urandom % 4) != 0);
      else ers_ready = 1'b0;
      prev_v = ers_valid;
      prev_r = ers_ready;
      prev_a = ers_addr;
      if (done) begin
        saw_done = 1'b1;
        done_err = err;
      end
      if (cyc > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  task automatic run_req(input longint s, input longint l, input int f, input string tag);
    int code;
    int w = 0;
    int n_exp;
    code = exp_code(s, l);
    if (code == 0) build_list(s, l); else exp_n = 0;
    n_exp = exp_n;
    if (code == 0 && f >= 0 && f < exp_n) begin
      code  = 2;
      n_exp = f + 1;
    end
    got_n = 0;
    fail_at = f;
    saw_done = 1'b0;
    @(negedge clk);
    req_start = AW'(s);
    req_len   = AW'(l);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && !req_ready, "R9 busy after accept", longint'({busy, req_ready}), 2);
    while (!saw_done && w < 5000) begin
      @(negedge clk);
      if (!saw_done) check(busy, "R9 busy held", longint'(busy), 1);
      w++;
    end
    check(saw_done, {tag, " done seen"}, longint'(saw_done), 1);
    check(done_err == 2'(code), {tag, " err"}, longint'(done_err), longint'(code));
    check(got_n == n_exp, {tag, " block count"}, longint'(got_n), longint'(n_exp));
    for (int i = 0; i < n_exp && i < got_n && i < 64; i++)
      check(longint'(got_addr[i]) == exp_addr[i], {tag, " R6 block address"},
            longint'(got_addr[i]), exp_addr[i]);
    @(negedge clk);
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !busy && !done && !ers_valid, "R1 reset state",
          longint'({req_ready, busy, done, ers_valid}), 8);

    run_req(0, SB, -1, "R8 single small");
    run_req(SB * 6, SB * 2 + LB, -1, "R6 crossing");
    run_req(0, DEV, -1, "R6 full device");
    run_req(DEV - LB, 2 * LB, -1, "R2 past end");
    run_req(32'hFFFF_0000, 32'h0002_0000, -1, "R2 wrap");
    run_req(SB / 2, SB / 2, -1, "R3 small start");
    run_req(S_END + SB, LB - SB, -1, "R3 large start");
    run_req(0, SB / 2, -1, "R4 small end");
    run_req(0, S_END + SB, -1, "R4 large end");
    run_req(12345, 0, -1, "R5 zero length");
    run_req(DEV + 4, 0, -1, "R2 zero length outside");
    run_req(0, DEV, 9, "R7 fail mid");
    run_req(SB * 7, SB + LB, 0, "R7 fail first");

    for (int k = 0; k < 40; k++) begin
      longint s, l;
      int f;
      int pick = int'($urandom % 4);
      if (pick == 0) s = longint'($urandom % 8) * SB;
      else if (pick == 1) s = S_END + longint'($urandom % 31) * LB;
      else if (pick == 2) s = longint'($urandom % 39) * SB;
      else s = longint'($urandom % 4096) * 1024;
      l = longint'($urandom % 12) * ((($urandom % 2) == 0) ? SB : LB);
      if (($urandom % 8) == 0) l = l + 4096;
      f = (($urandom % 3) == 0) ? int'($urandom % 6) : -1;
      run_req(s, l, f, "R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule